// File: doc/BRIEF.md
# Trigger Timing Sequencer

This block sits after the final decision logic of a trigger path. It takes the decision bits of one clock, folds them into a single final-trigger flag, and forms a decision word with that flag added on top. When the flag is seen while the sequencer is idle, the block counts a fixed number of clocks. It then issues a one-clock timing pulse and becomes ready for the next trigger. A busy flag marks the counting window. Any trigger that arrives inside that window is dropped.

The sequencer state and its counter are exposed as one packed register word. The timing result is a small output word that holds the pulse bit and a source code. Picking the source from per-subdetector timing inputs is not part of this block, so the source code is always zero.

Top module: `trig_timing_seq`

## Requirements
- R1: `decision_word[12:0]` equals `dec_bits`, and `decision_word[13]` is the OR of all 13 decision bits. Both are combinational.
- R2: While `rst` is high at a rising edge, the block clears. After that edge, `seq_reg` is 0, `busy` is 0 and `timing_out` is 0.
- R3: In idle, if the final-trigger flag is high at an edge, then after that edge the state is counting (1), the counter is 1 and `busy` is 1.
- R4: In idle, if the flag is low at an edge, the block stays idle with `busy` low and no pulse. The counter keeps its value.
- R5: While counting with a counter below 7, each edge adds one to the counter and keeps `busy` high.
- R6: While counting with the counter at 7, the next edge returns the block to idle, clears `busy` and raises the timing pulse. The pulse lasts exactly one clock. It therefore rises 7 clocks after `busy` rose.
- R7: A final-trigger flag that arrives while counting is ignored. This includes the cycle in which the counter is 7. The count is neither restarted nor extended.
- R8: `timing_out[0]` is the timing pulse. `timing_out[2:1]` is the source code and is always 0.
- R9: `seq_reg` layout: bit 0 is always 0, bits 3:1 hold the state (0 = idle, 1 = counting), and bits 6:4 hold the counter.
- R10: A flag that is high in the pulse cycle is accepted as a new trigger. `busy` rises on the same edge at which the pulse falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_bits | input | 13 | Decision bits of the current clock |
| decision_word | output | 14 | Decision bits with the final-trigger flag in bit 13 |
| seq_reg | output | 7 | Packed sequencer register (state, counter) |
| busy | output | 1 | High while the delay count runs |
| timing_out | output | 3 | Bit 0 timing pulse, bits 2:1 source code |

## Verification
Two functions can fall in the same cycle: ending a count and accepting a new trigger. The bench places a single-cycle trigger at every offset from the start of a count, through and past the pulse cycle. A trigger in the counter-7 cycle must be dropped. A trigger in the pulse cycle must restart the count on the edge that ends the pulse. Every cycle is then compared against a cycle model kept in the bench, and a long pseudo-random trigger stream with dense retriggers repeats that comparison.

// File: rtl/tts_pkg.sv
package tts_pkg;

    localparam int TTS_N_DEC    = 13;
    localparam int TTS_CNT_W    = 3;
    localparam int TTS_ST_W     = 3;
    localparam int TTS_SRC_W    = 2;
    localparam int TTS_LAST_CNT = 7;
    localparam int TTS_REG_W    = TTS_CNT_W + TTS_ST_W + 1;
    localparam int TTS_OUT_W    = TTS_SRC_W + 1;

    typedef enum logic [TTS_ST_W-1:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_COUNT = 3'd1
    } seq_state_e;

    // Packed so that the counter lands in [6:4] and the state in [3:1].
    typedef struct packed {
        logic [TTS_CNT_W-1:0] cnt;
        seq_state_e           st;
        logic                 spare;
    } seq_reg_t;

    typedef struct packed {
        logic [TTS_SRC_W-1:0] src;
        logic                 pulse;
    } timing_word_t;

    localparam seq_reg_t SEQ_RESET = '{cnt: '0, st: SEQ_IDLE, spare: 1'b0};

    function automatic logic any_set(input logic [TTS_N_DEC-1:0] v);
        return |v;
    endfunction

endpackage

// File: rtl/tts_flag_merge.sv
module tts_flag_merge
    import tts_pkg::*;
#(
    parameter int N_DEC = TTS_N_DEC
) (
    input  logic [N_DEC-1:0] dec_bits,
    output logic             trig_flag,
    output logic [N_DEC:0]   decision_word
);
    always_comb begin
        trig_flag     = any_set(dec_bits);
        decision_word = {trig_flag, dec_bits};
    end
endmodule

// File: rtl/tts_seq_core.sv
module tts_seq_core
    import tts_pkg::*;
#(
    parameter int LAST_CNT = TTS_LAST_CNT
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     trig_flag,
    output seq_reg_t seq_q,
    output logic     busy_q,
    output logic     pulse_q
);
    localparam logic [TTS_CNT_W-1:0] CNT_ONE  = TTS_CNT_W'(1);
    localparam logic [TTS_CNT_W-1:0] CNT_LAST = TTS_CNT_W'(LAST_CNT);

    seq_reg_t seq_d;
    logic     busy_d;
    logic     pulse_d;

    always_comb begin
        seq_d       = seq_q;
        seq_d.spare = 1'b0;
        busy_d      = busy_q;
        pulse_d     = 1'b0;
        case (seq_q.st)
            SEQ_IDLE: begin
                if (trig_flag) begin
                    seq_d.st  = SEQ_COUNT;
                    seq_d.cnt = CNT_ONE;
                    busy_d    = 1'b1;
                end else begin
                    busy_d    = 1'b0;
                end
            end
            SEQ_COUNT: begin
                if (seq_q.cnt == CNT_LAST) begin
                    seq_d.st = SEQ_IDLE;
                    busy_d   = 1'b0;
                    pulse_d  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_ONE;
                    busy_d    = 1'b1;
                end
            end
            default: begin
                seq_d.st = SEQ_IDLE;
                busy_d   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q   <= SEQ_RESET;
            busy_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            seq_q   <= seq_d;
            busy_q  <= busy_d;
            pulse_q <= pulse_d;
        end
    end
endmodule

// File: rtl/tts_out_pack.sv
module tts_out_pack
    import tts_pkg::*;
(
    input  logic                 pulse,
    output logic [TTS_OUT_W-1:0] timing_out
);
    timing_word_t w;
    always_comb begin
        w.pulse    = pulse;
        w.src      = '0;
        timing_out = w;
    end
endmodule

// File: rtl/trig_timing_seq.sv
module trig_timing_seq
    import tts_pkg::*;
#(
    parameter int N_DEC    = TTS_N_DEC,
    parameter int LAST_CNT = TTS_LAST_CNT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_DEC-1:0]     dec_bits,
    output logic [N_DEC:0]       decision_word,
    output logic [TTS_REG_W-1:0] seq_reg,
    output logic                 busy,
    output logic [TTS_OUT_W-1:0] timing_out
);
    logic     trig_flag;
    seq_reg_t seq_q;
    logic     pulse_q;

    tts_flag_merge #(.N_DEC(N_DEC)) merge_i (
        .dec_bits      (dec_bits),
        .trig_flag     (trig_flag),
        .decision_word (decision_word)
    );

    tts_seq_core #(.LAST_CNT(LAST_CNT)) core_i (
        .clk       (clk),
        .rst       (rst),
        .trig_flag (trig_flag),
        .seq_q     (seq_q),
        .busy_q    (busy),
        .pulse_q   (pulse_q)
    );

    tts_out_pack pack_i (
        .pulse      (pulse_q),
        .timing_out (timing_out)
    );

    assign seq_reg = seq_q;
endmodule

// File: rtl/tts_checker.sv
module tts_checker
    import tts_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [TTS_N_DEC-1:0] dec_bits,
    input logic [TTS_N_DEC:0]   decision_word,
    input logic [TTS_REG_W-1:0] seq_reg,
    input logic                 busy,
    input logic [TTS_OUT_W-1:0] timing_out
);
    logic                 flag;
    logic [TTS_CNT_W-1:0] cnt;
    assign flag = decision_word[TTS_N_DEC];
    assign cnt  = seq_reg[TTS_REG_W-1 -: TTS_CNT_W];

    assert_word_pass_R1: assert property (@(posedge clk) disable iff (rst)
        decision_word[TTS_N_DEC-1:0] == dec_bits);

    assert_reset_clear_R2: assert property (@(posedge clk)
        rst |=> (seq_reg == '0 && !busy && timing_out == '0));

    assert_start_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && flag) |=> (busy && cnt == TTS_CNT_W'(1)));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && !flag) |=> (!busy && !timing_out[0] && $stable(cnt)));

    assert_count_up_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != TTS_CNT_W'(TTS_LAST_CNT)) |=> (busy && cnt == $past(cnt) + TTS_CNT_W'(1)));

    assert_finish_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == TTS_CNT_W'(TTS_LAST_CNT)) |=> (!busy && timing_out[0]));

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
        timing_out[0] |=> !timing_out[0]);

    assert_src_zero_R8: assert property (@(posedge clk) disable iff (rst)
        timing_out[TTS_OUT_W-1:1] == '0);

    assert_layout_R9: assert property (@(posedge clk) disable iff (rst)
        !seq_reg[0] && (busy == (seq_reg[3:1] == 3'd1)));
endmodule

bind trig_timing_seq tts_checker chk_i (
    .clk           (clk),
    .rst           (rst),
    .dec_bits      (dec_bits),
    .decision_word (decision_word),
    .seq_reg       (seq_reg),
    .busy          (busy),
    .timing_out    (timing_out)
);

// File: tb/trig_timing_seq_tb_top.sv
`timescale 1ns/1ps
module trig_timing_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] dec_bits = '0;
    logic [13:0] decision_word;
    logic [6:0]  seq_reg;
    logic        busy;
    logic [2:0]  timing_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model
    int m_st = 0, m_cnt = 0;
    bit m_busy = 0, m_pulse = 0;

    always #4 clk = ~clk;

    trig_timing_seq dut_i (
        .clk(clk), .rst(rst), .dec_bits(dec_bits),
        .decision_word(decision_word), .seq_reg(seq_reg),
        .busy(busy), .timing_out(timing_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive, advance model at the edge, sample 2 ns after the edge
    task automatic cyc(input logic [12:0] v);
        string tag;
        bit f;
        dec_bits = v;
        f = (v != 0);
        if (m_st == 0) begin
            tag = m_pulse ? (f ? "R10" : "R4") : (f ? "R3" : "R4");
            if (f) begin m_st = 1; m_cnt = 1; m_busy = 1; end
            else m_busy = 0;
            m_pulse = 0;
        end else if (m_cnt == 7) begin
            tag = f ? "R7" : "R6";
            m_st = 0; m_busy = 0; m_pulse = 1;
        end else begin
            tag = f ? "R7" : "R5";
            m_cnt++; m_busy = 1; m_pulse = 0;
        end
        @(posedge clk);
        #2;
        chk({tag, " busy"}, busy, m_busy);
        chk({tag, " seq_reg"}, seq_reg, (m_cnt << 4) | (m_st << 1));
        chk({tag, " pulse"}, timing_out[0], m_pulse);
        chk("R8 source", timing_out[2:1], 0);
        chk("R9 spare bit", seq_reg[0], 0);
    endtask

    initial begin
        logic [15:0] lfsr;
        // R2: reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R2 seq_reg", seq_reg, 0);
        chk("R2 busy", busy, 0);
        chk("R2 timing_out", timing_out, 0);
        // R1: exhaustive decision pattern sweep (held in reset)
        for (int v = 0; v < 8192; v++) begin
            dec_bits = 13'(v);
            #1;
            chk("R1 word", decision_word, ((v != 0) ? 8192 : 0) + v);
        end
        dec_bits = '0;
        @(posedge clk); #2;
        rst = 1'b0;
        // R4: idle with no trigger
        for (int i = 0; i < 4; i++) cyc('0);
        // retrigger at every offset after a start (R3 R5 R6 R7 R10)
        for (int k = 1; k <= 10; k++) begin
            cyc(13'h0001 << (k % 13));
            for (int j = 1; j < k; j++) cyc('0);
            cyc(13'h1000);
            for (int j = 0; j < 12; j++) cyc('0);
        end
        // continuous trigger: back-to-back counts through pulse cycles (R10)
        for (int i = 0; i < 40; i++) cyc(13'h1fff);
        // R2: reset mid-count
        cyc(13'h0004); cyc('0); cyc('0);
        rst = 1'b1;
        @(posedge clk); #2;
        m_st = 0; m_cnt = 0; m_busy = 0; m_pulse = 0;
        chk("R2 mid-count seq_reg", seq_reg, 0);
        chk("R2 mid-count busy", busy, 0);
        chk("R2 mid-count timing_out", timing_out, 0);
        rst = 1'b0;
        // pseudo-random stream
        lfsr = 16'hace1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc((lfsr[2:0] < 3'd3) ? lfsr[15:3] : 13'h0);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule